// File: doc/BRIEF.md
# Eight-bit accumulator ALU with flags

This block is the arithmetic and logic stage of a small accumulator machine. It owns the 8-bit accumulator and five condition flags: sign, zero, auxiliary carry (the carry out of bit 3), parity and carry. Each strobed cycle it applies one operation. The operation is either a two-operand operation that combines the accumulator with a second operand, or a single-operand operation on the accumulator and the carry. The new accumulator and flags are committed in that same clock.

The second operand normally comes from the `operand` port, which the surrounding datapath fills from a register, memory or an immediate. The source selector value 3'b111 names the accumulator itself. This allows clearing by XOR with itself, and an accumulator can be loaded by clearing it and then OR-ing in a value. Instruction fetch, decoding, the register file and 16-bit pair arithmetic belong to other blocks.

Top module: `acc_alu8`

## Requirements
- R1: While reset is asserted and until it has been released through the two-stage synchronizer, the accumulator and all five flags read 0.
- R2: A cycle with `op_valid` low changes neither the accumulator nor any flag, whatever the other inputs carry.
- R3: For two-operand operations, `src_sel` = 3'b111 uses the current accumulator as the second operand and ignores `operand`. Every other `src_sel` value uses `operand`.
- R4: With `op_unary` low, code 000 adds and code 001 adds with the carry flag as carry-in. Carry becomes the carry out of bit 7 and auxiliary carry becomes the carry out of bit 3.
- R5: Code 010 subtracts and code 011 subtracts with the carry flag as borrow-in. Carry is set when the second operand plus borrow exceeds the accumulator as unsigned values. Auxiliary carry is the carry out of bit 3 of accumulator + inverted operand + inverted borrow.
- R6: Code 111 (compare) sets all five flags exactly as code 010 would, and it leaves the accumulator unchanged.
- R7: Codes 100 (AND), 101 (XOR) and 110 (OR) write the bitwise result and clear both carry and auxiliary carry.
- R8: After a two-operand operation or a decimal adjust, sign equals bit 7 of the computed result, zero is 1 exactly when that result is 0x00, and parity is 1 exactly when it has an even number of one bits. For compare, the computed result is the difference.
- R9: With `op_unary` high, code 100 is decimal adjust. It adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble of that sum exceeds 9, or carry is set, or the first step overflowed. Carry is set if that upper step was taken and is otherwise kept. Auxiliary carry becomes the carry out of bit 3 of the lower step, and 0 when no lower step was taken.
- R10: Unary codes 000, 001, 010 and 011 are, in that order, rotate left with bit 7 copied to carry, rotate right with bit 0 copied to carry, rotate left through carry, and rotate right through carry. None of them changes any flag other than carry.
- R11: Unary code 101 inverts all accumulator bits and changes no flag.
- R12: Unary code 110 sets carry to 1, and unary code 111 inverts carry. Neither changes the accumulator or any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Strobe: commit the operation this cycle |
| op_unary | input | 1 | 1 selects the single-operand group, 0 the two-operand group |
| op_code | input | 3 | Operation code within the selected group |
| src_sel | input | 3 | Second operand source; 3'b111 means the accumulator |
| operand | input | 8 | Second operand value from the datapath |
| acc_q | output | 8 | Accumulator |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Auxiliary carry flag |
| flag_p | output | 1 | Parity flag (even) |
| flag_cy | output | 1 | Carry / borrow flag |

## Verification
Decimal adjust can take its low-nibble correction and its high-nibble correction in the same cycle. The low correction can also carry into the high nibble and be the very thing that triggers the upper correction, as when an unadjusted sum of 0x9A becomes 0x00 with carry set. Every pair of two-digit decimal values is added and then adjusted. The adjusted accumulator and carry are then compared with a decimal sum formed directly in the bench, so every combination of the two corrections and of the incoming carry and auxiliary carry is reached.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int CODE_W = 3;
  localparam int SRC_W  = 3;

  localparam logic [SRC_W-1:0]  SRC_ACC  = '1;
  localparam logic [NIB_W-1:0]  DEC_MAX  = NIB_W'(9);
  localparam logic [NIB_W-1:0]  NIB_FIX  = NIB_W'(6);
  localparam logic [DATA_W-1:0] LO_ADJ   = DATA_W'(6);
  localparam logic [DATA_W-1:0] HI_ADJ   = DATA_W'(8'h60);

  typedef enum logic [CODE_W-1:0] {
    BOP_ADD = 3'd0,
    BOP_ADC = 3'd1,
    BOP_SUB = 3'd2,
    BOP_SBB = 3'd3,
    BOP_AND = 3'd4,
    BOP_XOR = 3'd5,
    BOP_OR  = 3'd6,
    BOP_CMP = 3'd7
  } bin_op_e;

  typedef enum logic [CODE_W-1:0] {
    UOP_ROLC = 3'd0,
    UOP_RORC = 3'd1,
    UOP_ROLT = 3'd2,
    UOP_RORT = 3'd3,
    UOP_DADJ = 3'd4,
    UOP_INV  = 3'd5,
    UOP_SETC = 3'd6,
    UOP_TOGC = 3'd7
  } un_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

endpackage

// File: rtl/acc_alu_szp.sv
module acc_alu_szp
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] val_i,
  output logic              s_o,
  output logic              z_o,
  output logic              p_o
);

  // sign, zero and even parity of a result byte
  always_comb begin
    s_o = val_i[DATA_W-1];
    z_o = (val_i == '0);
    p_o = ~(^val_i);
  end

endmodule

// File: rtl/acc_alu_binop.sv
module acc_alu_binop
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  bin_op_e           op_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              wr_o
);

  logic              is_sub;
  logic              use_cin;
  logic              cin;
  logic              c_eff;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;
  logic [NIB_W:0]    nib;

  // one shared adder: subtract is a + ~b + ~borrow, borrow is the inverted carry out
  always_comb begin
    is_sub  = (op_i == BOP_SUB) || (op_i == BOP_SBB) || (op_i == BOP_CMP);
    use_cin = (op_i == BOP_ADC) || (op_i == BOP_SBB);
    cin     = use_cin & cy_i;
    b_eff   = is_sub ? ~b_i : b_i;
    c_eff   = is_sub ? ~cin : cin;
    sum     = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
    nib     = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
  end

  always_comb begin
    wr_o = (op_i != BOP_CMP);
    case (op_i)
      BOP_AND: begin res_o = a_i & b_i; cy_o = 1'b0; ac_o = 1'b0; end
      BOP_XOR: begin res_o = a_i ^ b_i; cy_o = 1'b0; ac_o = 1'b0; end
      BOP_OR:  begin res_o = a_i | b_i; cy_o = 1'b0; ac_o = 1'b0; end
      default: begin
        res_o = sum[DATA_W-1:0];
        cy_o  = is_sub ? ~sum[DATA_W] : sum[DATA_W];
        ac_o  = nib[NIB_W];
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_unop.sv
module acc_alu_unop
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  un_op_e            op_i,
  input  logic              cy_i,
  input  logic              ac_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              ac_o,
  output logic              wr_o,
  output logic              upd_szp_o,
  output logic              upd_ac_o
);

  logic              lo_fix;
  logic              hi_fix;
  logic [NIB_W:0]    lo_sum;
  logic [DATA_W:0]   t_sum;
  logic [DATA_W-1:0] adj_res;

  // decimal adjust: both corrections chained in one cycle
  always_comb begin
    lo_fix  = (a_i[NIB_W-1:0] > DEC_MAX) | ac_i;
    lo_sum  = {1'b0, a_i[NIB_W-1:0]} + {1'b0, NIB_FIX};
    t_sum   = {1'b0, a_i} + (lo_fix ? {1'b0, LO_ADJ} : '0);
    hi_fix  = (t_sum[DATA_W-1:NIB_W] > DEC_MAX) | cy_i | t_sum[DATA_W];
    adj_res = t_sum[DATA_W-1:0] + (hi_fix ? HI_ADJ : '0);
  end

  always_comb begin
    res_o     = a_i;
    cy_o      = cy_i;
    ac_o      = ac_i;
    wr_o      = 1'b0;
    upd_szp_o = 1'b0;
    upd_ac_o  = 1'b0;
    case (op_i)
      UOP_ROLC: begin
        res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
        cy_o  = a_i[DATA_W-1];
        wr_o  = 1'b1;
      end
      UOP_RORC: begin
        res_o = {a_i[0], a_i[DATA_W-1:1]};
        cy_o  = a_i[0];
        wr_o  = 1'b1;
      end
      UOP_ROLT: begin
        res_o = {a_i[DATA_W-2:0], cy_i};
        cy_o  = a_i[DATA_W-1];
        wr_o  = 1'b1;
      end
      UOP_RORT: begin
        res_o = {cy_i, a_i[DATA_W-1:1]};
        cy_o  = a_i[0];
        wr_o  = 1'b1;
      end
      UOP_DADJ: begin
        res_o     = adj_res;
        cy_o      = cy_i | hi_fix;
        ac_o      = lo_fix & lo_sum[NIB_W];
        wr_o      = 1'b1;
        upd_szp_o = 1'b1;
        upd_ac_o  = 1'b1;
      end
      UOP_INV: begin
        res_o = ~a_i;
        wr_o  = 1'b1;
      end
      UOP_SETC: cy_o = 1'b1;
      UOP_TOGC: cy_o = ~cy_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_unary,
  input  logic [CODE_W-1:0] op_code,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_q,
  output logic              flag_s,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_p,
  output logic              flag_cy
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [DATA_W-1:0] acc_r;
  logic [DATA_W-1:0] acc_d;
  flags_t            fl_r;
  flags_t            fl_d;

  bin_op_e bop;
  un_op_e  uop;
  assign bop = bin_op_e'(op_code);
  assign uop = un_op_e'(op_code);

  logic [DATA_W-1:0] src_val;
  assign src_val = (src_sel == SRC_ACC) ? acc_r : operand;

  logic [DATA_W-1:0] bin_res;
  logic              bin_cy, bin_ac, bin_wr;

  acc_alu_binop u_binop (
    .a_i   (acc_r),
    .b_i   (src_val),
    .op_i  (bop),
    .cy_i  (fl_r.cy),
    .res_o (bin_res),
    .cy_o  (bin_cy),
    .ac_o  (bin_ac),
    .wr_o  (bin_wr)
  );

  logic [DATA_W-1:0] un_res;
  logic              un_cy, un_ac, un_wr, un_upd_szp, un_upd_ac;

  acc_alu_unop u_unop (
    .a_i       (acc_r),
    .op_i      (uop),
    .cy_i      (fl_r.cy),
    .ac_i      (fl_r.ac),
    .res_o     (un_res),
    .cy_o      (un_cy),
    .ac_o      (un_ac),
    .wr_o      (un_wr),
    .upd_szp_o (un_upd_szp),
    .upd_ac_o  (un_upd_ac)
  );

  logic [DATA_W-1:0] res_pick;
  logic              r_s, r_z, r_p;
  assign res_pick = op_unary ? un_res : bin_res;

  acc_alu_szp u_szp (
    .val_i (res_pick),
    .s_o   (r_s),
    .z_o   (r_z),
    .p_o   (r_p)
  );

  // next state
  always_comb begin
    acc_d = acc_r;
    fl_d  = fl_r;
    if (!op_unary) begin
      if (bin_wr) acc_d = bin_res;
      fl_d.s  = r_s;
      fl_d.z  = r_z;
      fl_d.p  = r_p;
      fl_d.ac = bin_ac;
      fl_d.cy = bin_cy;
    end else begin
      if (un_wr) acc_d = un_res;
      fl_d.cy = un_cy;
      if (un_upd_ac) fl_d.ac = un_ac;
      if (un_upd_szp) begin
        fl_d.s = r_s;
        fl_d.z = r_z;
        fl_d.p = r_p;
      end
    end
  end

  // state register with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_r <= '0;
      fl_r  <= '0;
    end else if (op_valid) begin
      acc_r <= acc_d;
      fl_r  <= fl_d;
    end
  end

  assign acc_q   = acc_r;
  assign flag_s  = fl_r.s;
  assign flag_z  = fl_r.z;
  assign flag_ac = fl_r.ac;
  assign flag_p  = fl_r.p;
  assign flag_cy = fl_r.cy;

  // checks beside the state they guard
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> ($stable(acc_q) && $stable({flag_s, flag_z, flag_ac, flag_p, flag_cy})));

  p_cmp_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !op_unary && bop == BOP_CMP) |=> $stable(acc_q));

  p_logic_clears_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !op_unary && (bop == BOP_AND || bop == BOP_XOR || bop == BOP_OR))
      |=> (!flag_cy && !flag_ac));

  p_zero_sign_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && !op_unary && bop != BOP_CMP)
      |=> ((flag_z == (acc_q == '0)) && (flag_s == acc_q[DATA_W-1])));

  p_adjust_keeps_cy_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_unary && uop == UOP_DADJ && flag_cy) |=> flag_cy);

  p_rotate_flags_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_unary && !op_code[CODE_W-1])
      |=> $stable({flag_s, flag_z, flag_ac, flag_p}));

  p_invert_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_unary && uop == UOP_INV)
      |=> ((acc_q == ~$past(acc_q)) && $stable({flag_s, flag_z, flag_ac, flag_p, flag_cy})));

  p_setc_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid && op_unary && uop == UOP_SETC) |=> (flag_cy && $stable(acc_q)));

endmodule

// File: tb/acc_alu8_test.sv
`timescale 1ns/1ps
module acc_alu8_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic       op_unary = 1'b0;
  logic [2:0] op_code = 3'd0;
  logic [2:0] src_sel = 3'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] acc_q;
  logic       flag_s, flag_z, flag_ac, flag_p, flag_cy;

  always #2 clk = ~clk;

  acc_alu8 uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_unary (op_unary),
    .op_code  (op_code),
    .src_sel  (src_sel),
    .operand  (operand),
    .acc_q    (acc_q),
    .flag_s   (flag_s),
    .flag_z   (flag_z),
    .flag_ac  (flag_ac),
    .flag_p   (flag_p),
    .flag_cy  (flag_cy)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench model state, flags ordered {s,z,ac,p,cy}
  int       m_acc = 0;
  bit [4:0] m_fl  = '0;

  function automatic bit even_par(int v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (v >> i) & 1;
    return (ones % 2) == 0;
  endfunction

  function automatic int bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  task automatic model_step(bit un, int code, int src, int opnd);
    int a, b, c, r, ncy, nac, lo, hi;
    bit wr, szp, acu;
    bit cy, ac;
    a = m_acc; cy = m_fl[0]; ac = m_fl[2];
    b = (src == 7) ? m_acc : opnd;
    wr = 1; szp = 1; acu = 1; ncy = cy; nac = ac; r = a;
    if (!un) begin
      case (code)
        0, 1: begin
          c = (code == 1) ? int'(cy) : 0;
          r = a + b + c; ncy = (r > 255); nac = ((a % 16) + (b % 16) + c) > 15; r = r & 255;
        end
        2, 3, 7: begin
          c = (code == 3) ? int'(cy) : 0;
          r = (a - b - c) & 255; ncy = (b + c) > a;
          nac = ((a % 16) + (15 - (b % 16)) + (1 - c)) > 15;
          wr = (code != 7);
        end
        4: begin r = a & b; ncy = 0; nac = 0; end
        5: begin r = a ^ b; ncy = 0; nac = 0; end
        default: begin r = a | b; ncy = 0; nac = 0; end
      endcase
    end else begin
      szp = 0; acu = 0;
      case (code)
        0: begin r = ((a << 1) | (a >> 7)) & 255; ncy = a >> 7; end
        1: begin r = (a >> 1) | ((a & 1) << 7); ncy = a & 1; end
        2: begin r = ((a << 1) & 255) | int'(cy); ncy = a >> 7; end
        3: begin r = (a >> 1) | (int'(cy) << 7); ncy = a & 1; end
        4: begin
          lo = ((a % 16) > 9) || ac;
          r = a + (lo ? 6 : 0);
          hi = (((r >> 4) & 15) > 9) || cy || (r > 255);
          r = (r + (hi ? 96 : 0)) & 255;
          ncy = cy | hi; nac = lo && ((a % 16) + 6 > 15);
          szp = 1; acu = 1;
        end
        5: r = (~a) & 255;
        6: begin ncy = 1; wr = 0; end
        default: begin ncy = !cy; wr = 0; end
      endcase
    end
    if (wr) m_acc = r;
    m_fl[0] = ncy[0];
    if (acu) m_fl[2] = nac[0];
    if (szp) begin
      m_fl[4] = r[7];
      m_fl[3] = (r == 0);
      m_fl[1] = even_par(r);
    end
  endtask

  task automatic check_state(string tag);
    bit [4:0] got;
    got = {flag_s, flag_z, flag_ac, flag_p, flag_cy};
    n_tests++;
    if (acc_q !== m_acc[7:0] || got !== m_fl) begin
      n_fail++;
      $display("FAIL %s acc=%h flags=%b expected acc=%h flags=%b", tag, acc_q, got, m_acc[7:0], m_fl);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic do_op(bit un, int code, int src, int opnd, string tag);
    op_valid = 1'b1; op_unary = un; op_code = code[2:0];
    src_sel = src[2:0]; operand = opnd[7:0];
    @(posedge clk);
    model_step(un, code, src, opnd);
    @(negedge clk);
    op_valid = 1'b0;
    check_state(tag);
  endtask

  task automatic idle_op(bit un, int code, int opnd, string tag);
    op_valid = 1'b0; op_unary = un; op_code = code[2:0];
    src_sel = 3'd0; operand = opnd[7:0];
    @(posedge clk);
    @(negedge clk);
    check_state(tag);
  endtask

  task automatic load_acc(int v);
    do_op(0, 5, 7, 8'hA5, "R3");
    do_op(0, 6, 0, v, "R7");
  endtask

  function automatic string bin_tag(int code);
    if (code < 2)  return "R4/R8";
    if (code < 4)  return "R5/R8";
    if (code == 7) return "R6/R8";
    return "R7/R8";
  endfunction

  function automatic string un_tag(int code);
    if (code < 4)  return "R10";
    if (code == 4) return "R9";
    if (code == 5) return "R11";
    return "R12";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired before the run completed");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int avals[8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'h5A};

    // R1: reset state, even with a strobed operation offered
    op_valid = 1'b1; op_unary = 1'b1; op_code = 3'd6;
    repeat (3) @(negedge clk);
    check_state("R1");
    op_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");
    repeat (3) @(negedge clk);
    check_state("R1");

    // R3: accumulator as source, operand ignored
    load_acc(8'h3C);
    do_op(0, 0, 7, 8'h01, "R3");
    do_op(0, 5, 7, 8'hFF, "R3");
    if (acc_q !== 8'h00) begin
      n_fail++;
      $display("FAIL R3 acc=%h expected acc=00", acc_q);
    end
    n_tests++;

    // R2: strobe low leaves everything in place
    load_acc(8'h96);
    do_op(1, 6, 0, 0, "R12");
    idle_op(1, 5, 8'h00, "R2");
    idle_op(0, 0, 8'hFF, "R2");
    idle_op(1, 7, 8'h12, "R2");

    // two-operand sweep
    foreach (avals[ai]) begin
      for (int b = 0; b < 256; b++) begin
        for (int code = 0; code < 8; code++) begin
          load_acc(avals[ai]);
          if (b[1]) do_op(1, 6, 0, 0, "R12");
          do_op(0, code, b[2:0] == 3'd7 ? 7 : (b % 7), b, bin_tag(code));
        end
      end
    end

    // single-operand sweep
    for (int a = 0; a < 256; a++) begin
      for (int cin = 0; cin < 2; cin++) begin
        for (int code = 0; code < 8; code++) begin
          load_acc(a);
          if (cin == 1) do_op(1, 6, 0, 0, "R12");
          do_op(1, code, 0, 0, un_tag(code));
        end
      end
    end

    // R9: every decimal pair, add then adjust, against a decimal sum
    for (int x = 0; x < 100; x++) begin
      for (int y = 0; y < 100; y++) begin
        load_acc(bcd(x));
        do_op(0, 0, 0, bcd(y), "R4");
        do_op(1, 4, 0, 0, "R9");
        n_tests++;
        if (acc_q !== bcd((x + y) % 100) || flag_cy !== ((x + y) >= 100)) begin
          n_fail++;
          $display("FAIL R9 %0d+%0d acc=%h cy=%b expected acc=%h cy=%b",
                   x, y, acc_q, flag_cy, bcd((x + y) % 100), (x + y) >= 100);
        end
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule